// File: doc/BRIEF.md
# Parallel Host Bus Transaction Sequencer

This block is a host-side master for a 16-bit parallel slave port with separate address and data pins. It takes one command at a time from a valid/ready request channel. Each command carries an address, a write word, a read/write flag and a two-bit byte-enable. The block turns the command into a timed sequence on the bus: chip select, address, an active-high read strobe or one or both byte write strobes, and the host data-bus drive with its output enable. When a command completes, it gives a one-cycle response pulse. For reads, the pulse comes with all 16 captured data bits.

Every transaction runs through the same phases: setup, strobe, hold and a completion cycle. The setup length, write pulse width, read wait and hold length are parameters counted in clock cycles. Back-pressure is plain. `req_ready` is high only while the sequencer is idle. A requester that raises `req_valid` must hold the request fields steady until it sees `req_ready` high at a clock edge, which is the edge where the request is taken. No second request is taken until the current one has finished and chip select has stayed low for at least one idle cycle.

Top module: `pbus_seq`

## Requirements
- R1: `req_ready` is high only while no transaction is in progress. A request is taken on the edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low from that edge until the completion cycle has passed. With `req_valid` low the bus stays idle.
- R2: For SETUP_CYC cycles after a request is taken, `bus_cs` is high, `bus_addr` shows the request address, and all strobes are low. The address stays stable while `bus_cs` is high.
- R3: For a read, `bus_rd` is high for RDWAIT_CYC cycles after setup. `bus_doe` is low during the whole read, and it is already low in the cycle before `bus_rd` rises.
- R4: Read data is captured as a full 16-bit word from `bus_din` at the end of the last `bus_rd` cycle. It appears on `rsp_rdata` in the completion cycle, where `rsp_valid` is high for exactly one cycle. Every transaction gives one such pulse.
- R5: For a write, `bus_doe` is high from the first setup cycle through the last hold cycle. The selected write strobes are high for PULSE_CYC cycles after setup.
- R6: Byte-enable bit 0 selects the low lane: `bus_wrl` and `bus_dout[7:0]`. Bit 1 selects the high lane: `bus_wrh` and `bus_dout[15:8]`. With both bits set, both strobes pulse in the same cycles. A lane that is not enabled drives zero and its strobe stays low.
- R7: A write with byte-enable 2'b00 runs the normal phase timing and completes with `rsp_valid`, but pulses no write strobe.
- R8: `bus_rd` is never high in the same cycle as `bus_wrl` or `bus_wrh`, and no strobe is high while `bus_cs` is low.
- R9: After the strobe phase, `bus_cs` stays high with all strobes low for HOLD_CYC cycles. `bus_cs` is low in the completion cycle and in at least one further cycle before the next transaction raises it.
- R10: While reset is asserted, `bus_cs`, `bus_rd`, `bus_wrl`, `bus_wrh`, `bus_doe` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request taken at this edge |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | 16 | Write word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-enable: bit 0 low lane, bit 1 high lane |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last captured read word |
| bus_cs | output | 1 | Chip select, active high |
| bus_addr | output | ADDR_W | Address bus |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wrl | output | 1 | Low-byte write strobe, active high |
| bus_wrh | output | 1 | High-byte write strobe, active high |
| bus_dout | output | 16 | Host data-bus drive value |
| bus_doe | output | 1 | Host data-bus output enable |
| bus_din | input | 16 | Data bus as seen from the slave |

## Verification
The bench builds the sequencer with a 6-bit address, a 2-cycle setup, a 2-cycle write pulse, a 3-cycle read wait and a 1-cycle hold, so one transaction lasts only a handful of cycles. With these values it can compare every bus pin in every cycle of every transaction. It sweeps all four byte-enable codes over several addresses and data words, and runs reads between the writes with no gap in the requests, which exercises turnaround and the idle gap. The slave model returns a wrong word on every read cycle except the last one, so a capture taken one cycle too early or too late shows up as a data mismatch.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int PBUS_DW    = 16;
  localparam int PBUS_LANES = PBUS_DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } pbus_state_e;
endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  // load wins; otherwise count down to zero and rest there
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/pbus_lane_drv.sv
module pbus_lane_drv #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]   be,
  input  logic [8*LANES-1:0] wdata,
  input  logic               strobe_en,
  input  logic               oe_en,
  output logic [LANES-1:0]   wr_str,
  output logic [8*LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_str[g]       = strobe_en & be[g];
    assign dout[8*g +: 8]  = (oe_en & be[g]) ? wdata[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/pbus_fsm.sv
module pbus_fsm
  import pbus_pkg::*;
#(
  parameter int SETUP_CYC  = 3,
  parameter int PULSE_CYC  = 4,
  parameter int RDWAIT_CYC = 5,
  parameter int HOLD_CYC   = 2,
  parameter int CW         = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        is_write,
  output pbus_state_e state,
  output logic        accept,
  output logic        cap_rd
);
  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC);
  localparam logic [CW-1:0] L_PULSE = CW'(PULSE_CYC);
  localparam logic [CW-1:0] L_RDWT  = CW'(RDWAIT_CYC);
  localparam logic [CW-1:0] L_HOLD  = CW'(HOLD_CYC);

  pbus_state_e   state_q, state_d;
  logic          tm_load, tm_last;
  logic [CW-1:0] tm_len;

  pbus_phase_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tm_load),
    .len  (tm_len),
    .last (tm_last)
  );

  always_comb begin
    state_d = state_q;
    tm_load = 1'b0;
    tm_len  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d = ST_SETUP; tm_load = 1'b1; tm_len = L_SETUP;
      end
      ST_SETUP: if (tm_last) begin
        state_d = ST_STROBE; tm_load = 1'b1;
        tm_len  = is_write ? L_PULSE : L_RDWT;
      end
      ST_STROBE: if (tm_last) begin
        state_d = ST_HOLD; tm_load = 1'b1; tm_len = L_HOLD;
      end
      ST_HOLD: if (tm_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state  = state_q;
  assign accept = (state_q == ST_IDLE) && req_valid;
  assign cap_rd = (state_q == ST_STROBE) && !is_write && tm_last;

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_DONE |=> state_q == ST_IDLE); // R9
  AST_STROBE_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STROBE && $past(state_q) != ST_STROBE) |-> $past(state_q) == ST_SETUP); // R2
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int SETUP_CYC  = 3,
  parameter int PULSE_CYC  = 4,
  parameter int RDWAIT_CYC = 5,
  parameter int HOLD_CYC   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [PBUS_DW-1:0]    req_wdata,
  input  logic                  req_write,
  input  logic [PBUS_LANES-1:0] req_be,
  output logic                  rsp_valid,
  output logic [PBUS_DW-1:0]    rsp_rdata,
  output logic                  bus_cs,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_rd,
  output logic                  bus_wrl,
  output logic                  bus_wrh,
  output logic [PBUS_DW-1:0]    bus_dout,
  output logic                  bus_doe,
  input  logic [PBUS_DW-1:0]    bus_din
);
  localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CD = (RDWAIT_CYC > HOLD_CYC) ? RDWAIT_CYC : HOLD_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAX_C + 1);

  pbus_state_e               state;
  logic                      accept, cap_rd;
  logic [ADDR_W-1:0]         addr_q;
  logic [PBUS_DW-1:0]        wdata_q, rdata_q;
  logic                      wr_q;
  logic [PBUS_LANES-1:0]     be_q;
  logic [PBUS_LANES-1:0]     wr_str;
  logic                      in_txn, in_strobe;

  pbus_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .RDWAIT_CYC(RDWAIT_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .is_write (wr_q),
    .state    (state),
    .accept   (accept),
    .cap_rd   (cap_rd)
  );

  // request capture on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
      be_q    <= req_be;
    end
  end

  // full-word read capture on the last read-wait cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= bus_din;
  end

  assign in_txn    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign in_strobe = (state == ST_STROBE);

  pbus_lane_drv #(.LANES(PBUS_LANES)) u_lanes (
    .be       (be_q),
    .wdata    (wdata_q),
    .strobe_en(in_strobe && wr_q),
    .oe_en    (in_txn && wr_q),
    .wr_str   (wr_str),
    .dout     (bus_dout)
  );

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign rsp_rdata = rdata_q;
  assign bus_cs    = in_txn;
  assign bus_addr  = addr_q;
  assign bus_rd    = in_strobe && !wr_q;
  assign bus_wrl   = wr_str[0];
  assign bus_wrh   = wr_str[PBUS_LANES-1];
  assign bus_doe   = in_txn && wr_q;

  AST_NO_RD_WR_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |-> !(bus_rd && (bus_wrl || bus_wrh))); // R8
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wrl || bus_wrh) |-> bus_cs); // R8
  AST_OE_CLEAR_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !bus_doe); // R3
  AST_OE_RELEASED_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> !$past(bus_doe)); // R3
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_cs); // R1
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs) |=> !bus_cs); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && $past(bus_cs)) |-> $stable(bus_addr)); // R2
endmodule

// File: tb/test_pbus_seq.sv
`timescale 1ns/1ps
module test_pbus_seq;
  localparam int AW = 6, S = 2, P = 2, RW = 3, H = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [1:0]    req_be;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          bus_cs, bus_rd, bus_wrl, bus_wrh, bus_doe;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_dout, bus_din;

  int  n_tests = 0, n_fail = 0;
  bit  finished = 0;
  int  rd_cnt = 0;

  pbus_seq #(.ADDR_W(AW), .SETUP_CYC(S), .PULSE_CYC(P), .RDWAIT_CYC(RW), .HOLD_CYC(H)) i_pbus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_cs(bus_cs), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wrl(bus_wrl), .bus_wrh(bus_wrh), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  function automatic logic [15:0] slave_word(logic [AW-1:0] a);
    return {~a, 4'hA, a};
  endfunction

  // slave: correct word only on the last read-wait cycle
  always @(negedge clk) begin
    if (bus_rd) begin
      rd_cnt = rd_cnt + 1;
      bus_din <= (rd_cnt == RW) ? slave_word(bus_addr) : ~slave_word(bus_addr);
    end else begin
      rd_cnt = 0;
      bus_din <= 16'h0000;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(bit wr, logic [AW-1:0] a, logic [15:0] d, logic [1:0] be);
    int n, t;
    logic [6:0] got, exp;
    logic [15:0] exp_dout;
    string tag;
    n = wr ? P : RW;
    t = S + n + H;
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1", "ready when idle", 32'(req_ready), 32'd1);
    chk(bus_cs == 1'b0, "R9", "cs low gap before txn", 32'(bus_cs), 32'd0);
    exp_dout = {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
    for (int k = 0; k <= t; k++) begin
      bit in_t, stb;
      @(negedge clk);
      in_t = (k < t);
      stb  = (k >= S) && (k < S + n);
      exp  = {in_t, !wr && stb, wr && stb && be[0], wr && stb && be[1],
              wr && in_t, k == t, 1'b0};
      got  = {bus_cs, bus_rd, bus_wrl, bus_wrh, bus_doe, rsp_valid, req_ready};
      if (k < S)          tag = "R2";
      else if (k < S + n) tag = wr ? ((be == 2'b00) ? "R7" : "R6") : "R3";
      else if (k < t)     tag = "R9";
      else                tag = "R4";
      chk(got == exp, tag, "cs,rd,wrl,wrh,oe,rsp,ready", 32'(got), 32'(exp));
      chk(!(bus_rd && (bus_wrl || bus_wrh)), "R8", "rd/wr overlap", 32'({bus_rd, bus_wrl, bus_wrh}), 32'd0);
      if (wr) chk(bus_doe == in_t, "R5", "write oe window", 32'(bus_doe), 32'(in_t));
      if (in_t) chk(bus_addr == a, "R2", "address", 32'(bus_addr), 32'(a));
      if (in_t && wr) chk(bus_dout == exp_dout, "R6", "lane data", 32'(bus_dout), 32'(exp_dout));
      if (k == t && !wr) chk(rsp_rdata == slave_word(a), "R4", "read word", 32'(rsp_rdata), 32'(slave_word(a)));
      if (k == t && wr && be == 2'b00) chk(rsp_valid == 1'b1, "R7", "zero-be completes", 32'(rsp_valid), 32'd1);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    bus_din = '0;
    repeat (3) @(negedge clk);
    chk({bus_cs, bus_rd, bus_wrl, bus_wrh, bus_doe, rsp_valid} == 6'b0, "R10", "reset outputs",
        32'({bus_cs, bus_rd, bus_wrl, bus_wrh, bus_doe, rsp_valid}), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 11 + 3);
      for (int b = 0; b < 4; b++)
        run(1'b1, a, 16'(16'h1357 * (i + 1) + b * 16'h0F0F), 2'(b));
      run(1'b0, a, 16'h0000, 2'b11);
      run(1'b0, ~a, 16'h0000, 2'b00);
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk({bus_cs, rsp_valid, req_ready} == 3'b001, "R1", "idle without request",
          32'({bus_cs, rsp_valid, req_ready}), 32'd1);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule